// File: doc/BRIEF.md
# Programmable Countdown Timer with Interrupt

This block is an 8-bit binary down-counter that software loads through a small register port. It steps on one of four source ticks, which a power-of-two prescaler and a divide-by-sixty stage derive from a reference tick input. With the default parameters these ticks run at 4096 Hz, 64 Hz, 1 Hz and one per minute from a 32.768 kHz reference. Each time the count runs out, the timer sets a sticky flag and reloads the value that was last written. It then keeps counting for as long as it is enabled.

An interrupt request comes from the flag in one of two ways. It can follow the flag as a level, or it can be a pulse of fixed width once per countdown period. The pulse width depends on the selected source and on whether the load value is 1. An external alarm event sets a second sticky flag. That flag is merged into the same active-low interrupt line and, when enabled, holds the line active whatever the timer mode.

There is no data stream here, so every pin is a plain control or status signal with no valid/ready handshake. A write takes effect at the clock edge where `wr_en` is high. Reads are combinational from `rd_addr`.

Top module: `tmr_top`

## Requirements
- R1: After reset, every register reads 0 and `irq_n` is high.
- R2: The source field of the control register (address 1) is held in bits 1:0. The code 0 steps every DIV_FAST reference ticks, 1 every DIV_MID, 2 every DIV_SLOW, and 3 every DIV_SLOW*MIN_DIV. All of these ticks come from one free-running prescaler.
- R3: While the enable bit (address 1, bit 7) is 1, the count (address 2) drops by one on each selected source tick. While the enable bit is 0, the count holds.
- R4: When a source tick arrives with the count at 1, the count reloads the last written value and the timer flag (address 0, bit 2) is set. Both become visible in the same cycle.
- R5: A written load value of 0 stops the timer. The count stays 0 and the flag is not set.
- R6: The timer flag and the alarm flag (address 0, bit 3, set by `alarm_hit`) are sticky. A write to address 0 with the flag's bit at 0 clears that flag, and with the bit at 1 leaves it as it is. A set in the same cycle wins over a clear.
- R7: With pulse mode off (address 0, bit 4 = 0) and the timer interrupt enable (address 0, bit 0) at 1, `irq_n` is low exactly while the timer flag is 1.
- R8: With pulse mode on, each expiry starts a low pulse on `irq_n` in the same cycle as the flag. The pulse lasts DIV_FAST/2 reference ticks for source 0 with load 1, DIV_FAST for source 0 with a larger load, DIV_MID/2 for source 1 with load 1, and DIV_MID in every other case.
- R9: While the alarm flag and the alarm interrupt enable (address 0, bit 1) are both 1, `irq_n` is held low in either timer mode.
- R10: The divide-by-MIN_DIV stage is cleared while the timer is disabled. After the enable bit rises, the first per-minute tick comes on the MIN_DIV-th slow tick.
- R11: Reads return {3'b0, pulse mode, alarm flag, timer flag, alarm enable, timer enable} at address 0, {enable, 5'b0, source} at address 1, the live count at address 2, and 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe at the reference rate |
| alarm_hit | input | 1 | One-cycle strobe that sets the alarm flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 irq/status, 1 control, 2 count) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle the rules that are local in time. A stopped counter stays at zero, and a disabled counter holds. A flag stays set until it is cleared. An expiry raises both the flag and the pulse on the next edge. An enabled alarm holds the line low, and level mode tracks the flag. The tick spacing of each source, the minute-stage restart on enable, and the exact pulse widths for each source and load value span many cycles. Those can only be shown by the bench scenarios, where a behavioural model is compared against every read address and `irq_n` on each clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    SRC_FAST = 2'd0,
    SRC_MID  = 2'd1,
    SRC_SLOW = 2'd2,
    SRC_MIN  = 2'd3
  } src_e;

  localparam logic [1:0] ADR_IRQ = 2'd0;
  localparam logic [1:0] ADR_CTL = 2'd1;
  localparam logic [1:0] ADR_CNT = 2'd2;

  localparam int B_TIE   = 0;
  localparam int B_AIE   = 1;
  localparam int B_TF    = 2;
  localparam int B_AF    = 3;
  localparam int B_PULSE = 4;
  localparam int B_EN    = 7;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale import tmr_pkg::*; #(
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 512,
  parameter int DIV_SLOW = 32768,
  parameter int MIN_DIV  = 60
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic en,
  input  src_e sel,
  output logic src_tick
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam int MW = $clog2(MIN_DIV);

  logic [PW-1:0] pre_q;
  logic [MW-1:0] min_q;
  logic t_fast, t_mid, t_slow, t_min;

  assign t_fast = ref_tick && ((pre_q & PW'(DIV_FAST - 1)) == PW'(DIV_FAST - 1));
  assign t_mid  = ref_tick && ((pre_q & PW'(DIV_MID - 1))  == PW'(DIV_MID - 1));
  assign t_slow = ref_tick && (pre_q == PW'(DIV_SLOW - 1));
  assign t_min  = t_slow && (min_q == MW'(MIN_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (ref_tick) pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) min_q <= '0;
    else if (!en) min_q <= '0;
    else if (t_slow) min_q <= t_min ? '0 : min_q + 1'b1;
  end

  always_comb begin
    unique case (sel)
      SRC_FAST: src_tick = t_fast;
      SRC_MID:  src_tick = t_mid;
      SRC_SLOW: src_tick = t_slow;
      default:  src_tick = t_min;
    endcase
  end
endmodule

// File: rtl/tmr_down.sv
module tmr_down #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          en,
  input  logic          src_tick,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] reload,
  output logic          expire
);
  logic step;

  assign step   = en && src_tick && (cnt != '0) && !load;
  assign expire = step && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      reload <= '0;
    end else if (load) begin
      cnt    <= load_val;
      reload <= load_val;
    end else if (step) begin
      cnt <= expire ? reload : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq import tmr_pkg::*; #(
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic expire,
  input  src_e sel,
  input  logic reload_one,
  input  logic alarm_hit,
  input  logic clr_tf,
  input  logic clr_af,
  input  logic tie,
  input  logic aie,
  input  logic pmode,
  output logic tf,
  output logic af,
  output logic pulse_act,
  output logic irq_n
);
  localparam int WW = $clog2(DIV_MID + 1);

  logic [WW-1:0] pw_q;
  logic [WW-1:0] width;

  always_comb begin
    unique case (sel)
      SRC_FAST: width = reload_one ? WW'(DIV_FAST / 2) : WW'(DIV_FAST);
      SRC_MID:  width = reload_one ? WW'(DIV_MID / 2)  : WW'(DIV_MID);
      default:  width = WW'(DIV_MID);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pw_q <= '0;
    else if (expire) pw_q <= width;
    else if (ref_tick && pw_q != '0) pw_q <= pw_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tf <= 1'b0;
      af <= 1'b0;
    end else begin
      if (expire) tf <= 1'b1;
      else if (clr_tf) tf <= 1'b0;
      if (alarm_hit) af <= 1'b1;
      else if (clr_af) af <= 1'b0;
    end
  end

  assign pulse_act = (pw_q != '0);
  assign irq_n = !((tie && (pmode ? pulse_act : tf)) || (aie && af));
endmodule

// File: rtl/tmr_top.sv
module tmr_top import tmr_pkg::*; #(
  parameter int DIV_FAST = 8,
  parameter int DIV_MID  = 512,
  parameter int DIV_SLOW = 32768,
  parameter int MIN_DIV  = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       alarm_hit,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       irq_n
);
  logic te_q, tie_q, aie_q, pmode_q;
  src_e sel_q;
  logic wr_irq, wr_ctl, load, clr_tf, clr_af;
  logic src_tick, expire, tf, af, pulse_act;
  logic [7:0] cnt, reload;

  assign wr_irq = wr_en && (wr_addr == ADR_IRQ);
  assign wr_ctl = wr_en && (wr_addr == ADR_CTL);
  assign load   = wr_en && (wr_addr == ADR_CNT);
  assign clr_tf = wr_irq && !wr_data[B_TF];
  assign clr_af = wr_irq && !wr_data[B_AF];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      te_q    <= 1'b0;
      sel_q   <= SRC_FAST;
      tie_q   <= 1'b0;
      aie_q   <= 1'b0;
      pmode_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        te_q  <= wr_data[B_EN];
        sel_q <= src_e'(wr_data[1:0]);
      end
      if (wr_irq) begin
        tie_q   <= wr_data[B_TIE];
        aie_q   <= wr_data[B_AIE];
        pmode_q <= wr_data[B_PULSE];
      end
    end
  end

  tmr_prescale #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW),
                 .MIN_DIV(MIN_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .en(te_q), .sel(sel_q),
    .src_tick(src_tick)
  );

  tmr_down #(.CW(8)) u_down (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(wr_data), .en(te_q),
    .src_tick(src_tick), .cnt(cnt), .reload(reload), .expire(expire)
  );

  tmr_irq #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID)) u_irq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .expire(expire), .sel(sel_q),
    .reload_one(reload == 8'd1), .alarm_hit(alarm_hit), .clr_tf(clr_tf),
    .clr_af(clr_af), .tie(tie_q), .aie(aie_q), .pmode(pmode_q), .tf(tf), .af(af),
    .pulse_act(pulse_act), .irq_n(irq_n)
  );

  always_comb begin
    unique case (rd_addr)
      ADR_IRQ: rd_data = {3'b000, pmode_q, af, tf, aie_q, tie_q};
      ADR_CTL: rd_data = {te_q, 5'b00000, sel_q};
      ADR_CNT: rd_data = cnt;
      default: rd_data = 8'h00;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       te,
  input logic       load,
  input logic [7:0] cnt,
  input logic       expire,
  input logic       tf,
  input logic       clr_tf,
  input logic       pulse_act,
  input logic       af,
  input logic       aie,
  input logic       tie,
  input logic       pmode,
  input logic       irq_n
);
  p_stop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0 && !load) |=> (cnt == 8'd0 && !tf) || $past(tf));

  p_zero_no_expire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == 8'd0) |-> !expire);

  p_hold_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!te && !load) |=> $stable(cnt));

  p_tf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tf && !clr_tf) |=> tf);

  p_tf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tf);

  p_pulse_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pulse_act);

  p_alarm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (af && aie) |-> !irq_n);

  p_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pmode && tie && tf) |-> !irq_n);
endmodule

bind tmr_top tmr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .te(te_q), .load(load), .cnt(cnt), .expire(expire),
  .tf(tf), .clr_tf(clr_tf), .pulse_act(pulse_act), .af(af), .aie(aie_q),
  .tie(tie_q), .pmode(pmode_q), .irq_n(irq_n)
);

// File: tb/tb_tmr_top.sv
`timescale 1ns/1ps
module tb_tmr_top;
  localparam int F = 4, M = 16, S = 64, MD = 3;

  logic clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, alarm_hit = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic irq_n;

  always #4 clk = ~clk;

  tmr_top #(.DIV_FAST(F), .DIV_MID(M), .DIV_SLOW(S), .MIN_DIV(MD)) dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .alarm_hit(alarm_hit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  // behavioural model state
  int m_pre, m_min, m_cnt, m_rel, m_pw, m_sel;
  bit m_te, m_tie, m_aie, m_pm, m_tf, m_af;
  int vectors = 0, fails = 0, cyc = 0;
  string req = "R1";
  bit done = 1'b0;

  function automatic int pulse_len(int sel, int n);
    if (sel == 0) return (n == 1) ? F / 2 : F;
    if (sel == 1) return (n == 1) ? M / 2 : M;
    return M;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pre = 0; m_min = 0; m_cnt = 0; m_rel = 0; m_pw = 0; m_sel = 0;
      m_te = 0; m_tie = 0; m_aie = 0; m_pm = 0; m_tf = 0; m_af = 0;
    end else begin
      bit tf_, tm_, ts_, tmin, src, ex;
      bit wi, wc, wl;
      tf_ = ref_tick && (m_pre % F == F - 1);
      tm_ = ref_tick && (m_pre % M == M - 1);
      ts_ = ref_tick && (m_pre == S - 1);
      tmin = ts_ && (m_min == MD - 1);
      src = (m_sel == 0) ? tf_ : (m_sel == 1) ? tm_ : (m_sel == 2) ? ts_ : tmin;
      wi = wr_en && wr_addr == 0;
      wc = wr_en && wr_addr == 1;
      wl = wr_en && wr_addr == 2;
      ex = 0;
      if (ref_tick) m_pre = (m_pre + 1) % S;
      if (!m_te) m_min = 0;
      else if (ts_) m_min = tmin ? 0 : m_min + 1;
      if (wl) begin
        m_cnt = wr_data; m_rel = wr_data;
      end else if (m_te && src && m_cnt != 0) begin
        if (m_cnt == 1) begin ex = 1; m_cnt = m_rel; end
        else m_cnt = m_cnt - 1;
      end
      if (ex) m_pw = pulse_len(m_sel, m_rel);
      else if (ref_tick && m_pw > 0) m_pw = m_pw - 1;
      if (ex) m_tf = 1; else if (wi && !wr_data[2]) m_tf = 0;
      if (alarm_hit) m_af = 1; else if (wi && !wr_data[3]) m_af = 0;
      if (wc) begin m_te = wr_data[7]; m_sel = wr_data[1:0]; end
      if (wi) begin m_tie = wr_data[0]; m_aie = wr_data[1]; m_pm = wr_data[4]; end
    end
    #2;
    begin
      logic [7:0] exp_rd;
      bit exp_irq;
      case (rd_addr)
        2'd0: exp_rd = {3'b0, m_pm, m_af, m_tf, m_aie, m_tie};
        2'd1: exp_rd = {m_te, 5'b0, 2'(m_sel)};
        2'd2: exp_rd = 8'(m_cnt);
        default: exp_rd = 8'h00;
      endcase
      exp_irq = !((m_tie && (m_pm ? (m_pw > 0) : m_tf)) || (m_aie && m_af));
      vectors++;
      if (rd_data !== exp_rd || irq_n !== exp_irq) begin
        fails++;
        $display("FAIL %s cyc %0d addr %0d: rd_data=%h irq_n=%b expected rd_data=%h irq_n=%b",
                 req, cyc, rd_addr, rd_data, irq_n, exp_rd, exp_irq);
      end
    end
  end

  // reference tick pattern and read-address rotation
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      ref_tick = (cyc % 5) != 3;
      rd_addr = 2'((cyc) % 4);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    req = "R1";
    idle(3);
    rst_n = 1'b1;
    idle(8);
    // R11: readback of control and count
    req = "R11";
    wr(2'd1, 8'h02);
    wr(2'd2, 8'd5);
    wr(2'd0, 8'h13);
    idle(8);
    wr(2'd0, 8'h00);
    // R3: disabled counter holds, then counts on fast source (R2 code 0)
    req = "R3";
    wr(2'd1, 8'h00);
    idle(30);
    wr(2'd0, 8'h01);
    req = "R4";
    wr(2'd1, 8'h80);
    idle(120);
    // R6: write 1 keeps flag, write 0 clears
    req = "R6";
    wr(2'd0, 8'h05);
    idle(4);
    wr(2'd0, 8'h01);
    idle(10);
    // R7: level mode follows flag
    req = "R7";
    wr(2'd1, 8'h81);
    wr(2'd2, 8'd2);
    idle(140);
    wr(2'd0, 8'h01);
    // R5: load of zero stops
    req = "R5";
    wr(2'd2, 8'd0);
    idle(100);
    // R8: pulse widths per source and load
    req = "R8";
    wr(2'd0, 8'h11);
    wr(2'd1, 8'h80);
    wr(2'd2, 8'd1);
    idle(60);
    wr(2'd2, 8'd3);
    idle(80);
    wr(2'd1, 8'h81);
    wr(2'd2, 8'd1);
    idle(120);
    wr(2'd2, 8'd2);
    idle(160);
    req = "R2";
    wr(2'd1, 8'h82);
    wr(2'd2, 8'd1);
    idle(260);
    // R10: minute stage restarts on enable
    req = "R10";
    wr(2'd1, 8'h03);
    wr(2'd2, 8'd1);
    idle(50);
    wr(2'd1, 8'h83);
    idle(520);
    wr(2'd1, 8'h03);
    idle(20);
    wr(2'd1, 8'h83);
    idle(300);
    // R9: alarm overrides pulse mode; set wins over clear
    req = "R9";
    wr(2'd1, 8'h80);
    wr(2'd2, 8'd4);
    wr(2'd0, 8'h13);
    @(negedge clk); alarm_hit = 1'b1;
    @(negedge clk); alarm_hit = 1'b0;
    idle(80);
    req = "R6";
    @(negedge clk);
    alarm_hit = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 8'h13;
    @(negedge clk);
    alarm_hit = 1'b0; wr_en = 1'b0;
    idle(10);
    wr(2'd0, 8'h17);
    idle(20);
    req = "R1";
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(8);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog %s: expected completion, got hang", req);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule